// File: doc/BRIEF.md
# Host-Resident Interrupt Vector Fetch Engine

This block sits inside a device and raises message-signalled interrupts when the table of interrupt vectors is kept in host memory and not in local registers. Each vector is 96 bits wide: a 64-bit message address and a 32-bit message data word. When an interrupt is requested for a vector number, the engine first looks in a small local cache of vectors it has already fetched. On a hit it sends the message write at once. On a miss it issues two non-posted reads in sequence. The first fetches the address and the second fetches the data word. Only when both answers are back does it send the posted write, which carries the data word to the fetched address.

Vectors change rarely, so cached entries stay useful for a long time. An invalidate pulse discards every cached entry. If a fetch is running when the pulse arrives, its result is not kept. Only one interrupt is handled at a time. The request port stays not-ready until the outgoing write has been accepted.

All data ports are valid/ready. A source holds valid and its payload steady until ready is seen at a clock edge. The engine holds its own read request and write payloads steady while they stall. Read completions have no ready signal: the engine samples them whenever they are offered.

Top module: `msix_fetch_seq`

## Requirements
- R1: Out of reset, `irq_ready` is 1 and both `rd_req_valid` and `wr_valid` are 0.
- R2: A request whose vector is cached produces `wr_valid` in the cycle that follows the accepting edge, and no read request is issued for it.
- R3: On a miss, exactly two reads are issued in this order: first `tbl_base + 16*N` (the address word), then `tbl_base + 16*N + 8` (the data word). The second read is issued only after the first completion has been taken.
- R4: After a miss, the write carries bits [63:0] of the first completion as `wr_addr` and bits [31:0] of the second completion as `wr_data`.
- R5: The cache holds 8 vectors and is fully associative. Each vector that is fetched and completes without an intervening invalidate is stored, and a later request for it hits.
- R6: Replacement is round-robin over fills. The ninth distinct fill evicts the first vector that was filled.
- R7: A completion whose `rd_cpl_tag` differs from the tag of the outstanding read is ignored and changes neither the read order nor the written values.
- R8: An `inv` pulse empties the cache, so the next request for any vector misses. If the pulse lands during a fetch, that fetch still produces a correct write, but its vector is not stored.
- R9: Only one interrupt is handled at a time. `irq_ready` stays low from acceptance until the write handshake completes. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 64 | Host address of vector 0 (static) |
| inv | input | 1 | Cache invalidate pulse |
| irq_valid | input | 1 | Interrupt request valid |
| irq_ready | output | 1 | Engine can accept a request |
| irq_vec | input | 11 | Vector number of the request |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Host address to read |
| rd_req_tag | output | 5 | Tag of the read request |
| rd_cpl_valid | input | 1 | Read completion present |
| rd_cpl_tag | input | 5 | Tag of the completion |
| rd_cpl_data | input | 64 | Completion payload |
| wr_valid | output | 1 | Posted message write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message data |

## Verification
A hit is due in the cycle after the accepting edge. The bench drives the request at a falling edge and samples `wr_valid` at the very next falling edge. A miss has no fixed latency, because it depends on the host model. For a miss the bench waits in a bounded loop, then checks the logged read addresses, the read count and the write payload. The effect of an invalidate, or of a foreign-tag completion, is checked by issuing the same vector again and observing whether its reads reappear.

// File: rtl/msix_fetch_pkg.sv
package msix_fetch_pkg;
  // entry layout in host memory: 16-byte stride, address word then data word
  localparam int unsigned STRIDE_LG = 4;
  localparam int unsigned DATA_OFS  = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR_REQ,
    S_ADDR_WAIT,
    S_DATA_REQ,
    S_DATA_WAIT,
    S_SEND
  } seq_state_t;
endpackage

// File: rtl/msix_vec_cache.sv
module msix_vec_cache #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VEC_W   = 11,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  look_vec,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [DATA_W-1:0] hit_data,
  input  logic              fill_en,
  input  logic [VEC_W-1:0]  fill_vec,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              flush
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [VEC_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_vec);
  end

  always_comb begin
    hit_addr = '0;
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_addr = hit_addr | addr_q[i];
        hit_data = hit_data | data_q[i];
      end
    end
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[rr_q]  <= 1'b1;
      tag_q[rr_q]  <= fill_vec;
      addr_q[rr_q] <= fill_addr;
      data_q[rr_q] <= fill_data;
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

// File: rtl/msix_seq_ctrl.sv
module msix_seq_ctrl
  import msix_fetch_pkg::*;
#(
  parameter int unsigned VEC_W  = 11,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              inv,
  input  logic              irq_valid,
  output logic              irq_ready,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              c_hit,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  output logic              fill_en,
  output logic [VEC_W-1:0]  fill_vec,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [TAG_W-1:0]  rd_req_tag,
  input  logic              rd_cpl_valid,
  input  logic [TAG_W-1:0]  rd_cpl_tag,
  input  logic [ADDR_W-1:0] rd_cpl_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  seq_state_t        st_q;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  next_tag_q, out_tag_q;
  logic              stale_q;
  logic              use_hit, cpl_ok;
  logic [ADDR_W-1:0] entry_base;

  // an invalidate in the lookup cycle wins over the hit
  assign use_hit    = c_hit && !inv;
  assign cpl_ok     = rd_cpl_valid && (rd_cpl_tag == out_tag_q);
  assign entry_base = tbl_base + (ADDR_W'(vec_q) << STRIDE_LG);

  assign irq_ready    = (st_q == S_IDLE);
  assign rd_req_valid = (st_q == S_ADDR_REQ) || (st_q == S_DATA_REQ);
  assign rd_req_addr  = (st_q == S_DATA_REQ) ? entry_base + ADDR_W'(DATA_OFS) : entry_base;
  assign rd_req_tag   = next_tag_q;
  assign wr_valid     = (st_q == S_SEND);
  assign wr_addr      = addr_q;
  assign wr_data      = data_q;

  assign fill_en   = (st_q == S_DATA_WAIT) && cpl_ok && !stale_q && !inv;
  assign fill_vec  = vec_q;
  assign fill_addr = addr_q;
  assign fill_data = rd_cpl_data[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      vec_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      next_tag_q <= '0;
      out_tag_q  <= '0;
      stale_q    <= 1'b0;
    end else begin
      if (inv && st_q != S_IDLE) stale_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (irq_valid) begin
          vec_q   <= irq_vec;
          stale_q <= 1'b0;
          if (use_hit) begin
            addr_q <= c_addr;
            data_q <= c_data;
            st_q   <= S_SEND;
          end else begin
            st_q <= S_ADDR_REQ;
          end
        end
        S_ADDR_REQ, S_DATA_REQ: if (rd_req_ready) begin
          out_tag_q  <= next_tag_q;
          next_tag_q <= next_tag_q + 1'b1;
          st_q       <= (st_q == S_ADDR_REQ) ? S_ADDR_WAIT : S_DATA_WAIT;
        end
        S_ADDR_WAIT: if (cpl_ok) begin
          addr_q <= rd_cpl_data;
          st_q   <= S_DATA_REQ;
        end
        S_DATA_WAIT: if (cpl_ok) begin
          data_q <= rd_cpl_data[DATA_W-1:0];
          st_q   <= S_SEND;
        end
        S_SEND: if (wr_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9
  one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_ready);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
endmodule

// File: rtl/msix_fetch_seq.sv
module msix_fetch_seq #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VEC_W   = 11,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TAG_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              inv,
  input  logic              irq_valid,
  output logic              irq_ready,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [TAG_W-1:0]  rd_req_tag,
  input  logic              rd_cpl_valid,
  input  logic [TAG_W-1:0]  rd_cpl_tag,
  input  logic [ADDR_W-1:0] rd_cpl_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              c_hit, fill_en;
  logic [ADDR_W-1:0] c_addr, fill_addr;
  logic [DATA_W-1:0] c_data, fill_data;
  logic [VEC_W-1:0]  fill_vec;

  msix_vec_cache #(.ENTRIES(ENTRIES), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .look_vec(irq_vec),
    .hit(c_hit), .hit_addr(c_addr), .hit_data(c_data),
    .fill_en(fill_en), .fill_vec(fill_vec), .fill_addr(fill_addr), .fill_data(fill_data),
    .flush(inv)
  );

  msix_seq_ctrl #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .inv(inv),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
    .c_hit(c_hit), .c_addr(c_addr), .c_data(c_data),
    .fill_en(fill_en), .fill_vec(fill_vec), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_tag(rd_req_tag),
    .rd_cpl_valid(rd_cpl_valid), .rd_cpl_tag(rd_cpl_tag), .rd_cpl_data(rd_cpl_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/msix_fetch_seq_bench.sv
module msix_fetch_seq_bench;
  localparam logic [63:0] BASE = 64'h0000_0040_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv = 1'b0, irq_valid = 1'b0, rd_req_ready = 1'b1;
  logic rd_cpl_valid = 1'b0, wr_ready = 1'b0;
  logic [10:0] irq_vec = '0;
  logic [4:0]  rd_cpl_tag = '0;
  logic [63:0] rd_cpl_data = '0;
  logic irq_ready, rd_req_valid, wr_valid;
  logic [63:0] rd_req_addr, wr_addr;
  logic [4:0]  rd_req_tag;
  logic [31:0] wr_data;

  int tests = 0, fails = 0, rd_cnt = 0;
  logic [63:0] rd_log [64];
  logic bad_inject = 1'b0;

  always #10 clk = ~clk;

  msix_fetch_seq u_msix_fetch_seq (
    .clk(clk), .rst_n(rst_n), .tbl_base(BASE), .inv(inv),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_tag(rd_req_tag),
    .rd_cpl_valid(rd_cpl_valid), .rd_cpl_tag(rd_cpl_tag), .rd_cpl_data(rd_cpl_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [63:0] mem_addr(input logic [10:0] v);
    return 64'hFEE0_0000_0000_0010 | (64'(v) << 12);
  endfunction
  function automatic logic [31:0] mem_data(input logic [10:0] v);
    return 32'hC0DE_0000 ^ 32'(v);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // host memory model: answers each read after two cycles
  initial begin
    forever begin
      @(negedge clk);
      rd_cpl_valid = 1'b0;
      if (rd_req_valid) begin
        logic [63:0] a, ofs;
        logic [4:0]  t;
        logic [10:0] v;
        a = rd_req_addr; t = rd_req_tag;
        if (rd_cnt < 64) rd_log[rd_cnt] = a;
        rd_cnt++;
        ofs = a - BASE; v = ofs[14:4];
        repeat (2) @(negedge clk);
        if (bad_inject) begin
          rd_cpl_valid = 1'b1; rd_cpl_tag = t ^ 5'd1; rd_cpl_data = '1;
          @(negedge clk);
        end
        rd_cpl_valid = 1'b1; rd_cpl_tag = t;
        rd_cpl_data = ofs[3] ? {32'h5A5A_5A5A, mem_data(v)} : mem_addr(v);
      end
    end
  end

  task automatic do_irq(input logic [10:0] v, input logic exp_hit, input logic inv_mid,
                        input logic bad, input logic stall, input string req);
    int n, r0;
    r0 = rd_cnt; bad_inject = bad; n = 0;
    @(negedge clk); irq_vec = v; irq_valid = 1'b1;
    while (!irq_ready) @(negedge clk);
    @(negedge clk); irq_valid = 1'b0;
    if (inv_mid) begin @(negedge clk); inv = 1'b1; @(negedge clk); inv = 1'b0; end
    while (!wr_valid && n < 200) begin @(negedge clk); n++; end
    if (exp_hit) chk(n == 0, {req, " hit latency"}, 64'(n), 64'd0);
    chk(rd_cnt - r0 == (exp_hit ? 0 : 2), {req, " read count"}, 64'(rd_cnt - r0), exp_hit ? 64'd0 : 64'd2);
    if (!exp_hit && rd_cnt - r0 == 2) begin
      chk(rd_log[r0] == BASE + 64'(v) * 16, {req, " R3 first read"}, rd_log[r0], BASE + 64'(v) * 16);
      chk(rd_log[r0+1] == BASE + 64'(v) * 16 + 8, {req, " R3 second read"}, rd_log[r0+1], BASE + 64'(v) * 16 + 8);
    end
    chk(wr_valid && wr_addr == mem_addr(v), {req, " R4 address"}, wr_addr, mem_addr(v));
    chk(wr_data == mem_data(v), {req, " R4 data"}, 64'(wr_data), 64'(mem_data(v)));
    if (stall) begin
      repeat (3) @(negedge clk);
      chk(wr_valid && wr_addr == mem_addr(v) && !irq_ready, "R9 stall hold", {63'd0, wr_valid}, 64'd1);
    end
    wr_ready = 1'b1; @(negedge clk); wr_ready = 1'b0;
    chk(!wr_valid && irq_ready, "R9 release", {62'd0, wr_valid, irq_ready}, 64'd1);
    bad_inject = 1'b0;
  endtask

  // {expect hit, vector}: fill 8, evict oldest on the ninth (R5, R6)
  localparam logic [11:0] VECS [13] = '{
    {1'b0, 11'd3},  {1'b1, 11'd3},  {1'b0, 11'd5},  {1'b0, 11'd7},
    {1'b0, 11'd9},  {1'b0, 11'd11}, {1'b0, 11'd13}, {1'b0, 11'd15},
    {1'b0, 11'd17}, {1'b0, 11'd19}, {1'b1, 11'd5},  {1'b0, 11'd3},
    {1'b0, 11'd5}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_ready && !rd_req_valid && !wr_valid, "R1 reset", {61'd0, irq_ready, rd_req_valid, wr_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_ready && !rd_req_valid && !wr_valid, "R1 after reset", {61'd0, irq_ready, rd_req_valid, wr_valid}, 64'd4);
    for (int i = 0; i < 13; i++)
      do_irq(VECS[i][10:0], VECS[i][11], 1'b0, 1'b0, (i == 1), VECS[i][11] ? "R2/R5" : "R6 miss");
    // R8: idle invalidate empties cache
    do_irq(11'd5, 1'b1, 1'b0, 1'b0, 1'b0, "R5 refill hit");
    @(negedge clk); inv = 1'b1; @(negedge clk); inv = 1'b0;
    do_irq(11'd5, 1'b0, 1'b0, 1'b0, 1'b0, "R8 idle flush");
    // R8: invalidate during fetch, result not cached
    do_irq(11'd21, 1'b0, 1'b1, 1'b0, 1'b0, "R8 mid fetch");
    do_irq(11'd21, 1'b0, 1'b0, 1'b0, 1'b0, "R8 not stored");
    do_irq(11'd21, 1'b1, 1'b0, 1'b0, 1'b0, "R5 now stored");
    // R7: foreign-tag completion ignored
    do_irq(11'd1500, 1'b0, 1'b0, 1'b1, 1'b1, "R7 bad tag");
    do_irq(11'd1500, 1'b1, 1'b0, 1'b0, 1'b0, "R7 then hit");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule